// File: doc/BRIEF.md
# Push-down stack pointer engine

This block carries out the five stack instructions of a 36-bit word machine. These are push, push-and-jump, pop, pop-and-jump and adjust-stack-pointer. A stack pointer word holds a negative remaining count in its left half and a word address in its right half. When the engine is idle, it accepts one instruction on a `start` pulse. It takes the opcode, the pointer read from the accumulator, an operand and the effective address E. The operand is the data word for push and the return PC for push-and-jump.

The engine makes at most two stack-memory accesses, one at a time, each over a request/acknowledge handshake. It then presents the updated pointer for writeback to the accumulator for one cycle. For the jump forms, it gives the jump target in that same cycle. If the instruction overflowed, underflowed or flipped the pointer's sign the wrong way, a one-cycle trap request follows the writeback cycle.

Top module: `stack_ptr_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_req`, `sp_we`, `jump_valid` and `trap` are all low.
- R2: Push (opcode octal 261) adds 1 to each half of the pointer separately, with each half wrapping within 18 bits. It writes `operand` at the new right-half address, then presents the new pointer on `sp_out` with `sp_we` high for one cycle.
- R3: Push-and-jump (opcode octal 260) handles the pointer as push does, but the word it stores is `operand`+1 modulo 2^36. In the writeback cycle `jump_valid` is high and `jump_target` equals E.
- R4: If the left half is all ones before a push or push-and-jump, the store and the writeback still take place with a left half of zero, and a trap is requested.
- R5: Pop (opcode octal 262) reads the word at the current right-half address and writes it to address E. It decrements each half by 1 with no borrow between the halves, and writes the result back.
- R6: Pop-and-jump (opcode octal 263) reads the word at the current right-half address and decrements the pointer as pop does. In the writeback cycle it raises `jump_valid`, with `jump_target` set to bits 17:0 of the word read.
- R7: If the left half is zero before a pop or pop-and-jump, which means the left-half decrement gives no carry out of bit 0, a trap is requested after the writeback.
- R8: Adjust (opcode octal 105) adds E to each half separately, with no carry between the halves, and makes no memory request. Writeback appears in the cycle after the accepting edge.
- R9: Adjust traps in two cases. With E bit 17 set, it traps when pointer bit 35 goes from 1 to 0. With E bit 17 clear, it traps when pointer bit 35 goes from 0 to 1. In every other case it does not trap.
- R10: A `start` whose opcode is none of the five above is ignored. The engine stays idle and makes no request or writeback.
- R11: Only one memory request is outstanding at a time. A request holds its address, direction and write data steady until the cycle in which `mem_ack` is sampled high.
- R12: A `start` that arrives while `busy` is high has no effect on the instruction in progress.
- R13: The trap request is a single-cycle pulse in the cycle right after the writeback cycle. `busy` stays high through that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (taken only while idle) |
| opcode | input | 9 | Instruction opcode |
| sp_in | input | 36 | Stack pointer from the accumulator |
| operand | input | 36 | Data word (push) or return PC (push-and-jump) |
| ea | input | 18 | Effective address E |
| busy | output | 1 | An instruction is in progress |
| mem_req | output | 1 | Stack memory request |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | 18 | Request address |
| mem_wdata | output | 36 | Write data |
| mem_ack | input | 1 | Request completes in this cycle |
| mem_rdata | input | 36 | Read data, valid with `mem_ack` |
| sp_we | output | 1 | Pointer writeback strobe |
| sp_out | output | 36 | Updated pointer |
| jump_valid | output | 1 | Jump target is valid (writeback cycle) |
| jump_target | output | 18 | New program counter |
| trap | output | 1 | Overflow or underflow trap request |

## Verification
In the writeback cycle of the jump forms, the pointer writeback and the jump redirect fall together. For an overflowing push-and-jump, the trap decision is also settled by then, and it is presented in the next cycle. The bench provokes these overlaps with push-and-jump at an all-ones count and pop-and-jump at a zero count. A behavioural model predicts every output on every clock, so the bench checks that the target, the new pointer and the store arrive together, and that the trap pulse lands exactly one cycle later. A second overlap is a new `start` held high while a stalled request is still pending. The bench judges it by confirming that the pending request's address and data do not move.

// File: rtl/stack_ptr_engine.sv
module stack_ptr_engine #(
  parameter int HW  = 18,
  parameter int OPW = 9,
  parameter logic [OPW-1:0] OP_PUSHJ = 'o260,
  parameter logic [OPW-1:0] OP_PUSH  = 'o261,
  parameter logic [OPW-1:0] OP_POP   = 'o262,
  parameter logic [OPW-1:0] OP_POPJ  = 'o263,
  parameter logic [OPW-1:0] OP_ADJ   = 'o105
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OPW-1:0]    opcode,
  input  logic [2*HW-1:0]   sp_in,
  input  logic [2*HW-1:0]   operand,
  input  logic [HW-1:0]     ea,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [HW-1:0]     mem_addr,
  output logic [2*HW-1:0]   mem_wdata,
  input  logic              mem_ack,
  input  logic [2*HW-1:0]   mem_rdata,
  output logic              sp_we,
  output logic [2*HW-1:0]   sp_out,
  output logic              jump_valid,
  output logic [HW-1:0]     jump_target,
  output logic              trap
);
  localparam int W = 2*HW;

  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_RD, S_WR, S_FIN, S_TRAP} state_t;
  typedef enum logic [2:0] {K_PUSH, K_PUSHJ, K_POP, K_POPJ, K_ADJ, K_NONE} kind_t;

  state_t st;
  kind_t  kind, k_q;

  logic [W-1:0]  ptr_q, wdata_q;
  logic [HW-1:0] addr_q, tgt_q;
  logic          trap_q;

  logic [HW-1:0] sp_l, sp_r;
  assign sp_l = sp_in[W-1:HW];
  assign sp_r = sp_in[HW-1:0];

  logic [HW:0]   l_inc, l_dec;
  logic [HW-1:0] r_inc, r_dec, l_adj, r_adj;
  logic          adj_trap;

  assign l_inc = {1'b0, sp_l} + (HW+1)'(1);
  assign r_inc = sp_r + HW'(1);
  assign l_dec = {1'b0, sp_l} + {1'b0, {HW{1'b1}}};
  assign r_dec = sp_r - HW'(1);
  assign l_adj = sp_l + ea;
  assign r_adj = sp_r + ea;
  assign adj_trap = ea[HW-1] ? (sp_l[HW-1] & ~l_adj[HW-1])
                             : (~sp_l[HW-1] & l_adj[HW-1]);

  always_comb begin
    if      (opcode == OP_PUSH)  kind = K_PUSH;
    else if (opcode == OP_PUSHJ) kind = K_PUSHJ;
    else if (opcode == OP_POP)   kind = K_POP;
    else if (opcode == OP_POPJ)  kind = K_POPJ;
    else if (opcode == OP_ADJ)   kind = K_ADJ;
    else                         kind = K_NONE;
  end

  logic accept;
  assign accept = start && (st == S_IDLE) && (kind != K_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      k_q     <= K_PUSH;
      ptr_q   <= '0;
      wdata_q <= '0;
      addr_q  <= '0;
      tgt_q   <= '0;
      trap_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          k_q   <= kind;
          tgt_q <= ea;
          case (kind)
            K_PUSH, K_PUSHJ: begin
              ptr_q   <= {l_inc[HW-1:0], r_inc};
              addr_q  <= r_inc;
              wdata_q <= (kind == K_PUSHJ) ? operand + W'(1) : operand;
              trap_q  <= l_inc[HW];
              st      <= S_PUSH;
            end
            K_POP, K_POPJ: begin
              ptr_q  <= {l_dec[HW-1:0], r_dec};
              addr_q <= sp_r;
              trap_q <= ~l_dec[HW];
              st     <= S_RD;
            end
            default: begin
              ptr_q  <= {l_adj, r_adj};
              trap_q <= adj_trap;
              st     <= S_FIN;
            end
          endcase
        end
        S_PUSH: if (mem_ack) st <= S_FIN;
        S_RD: if (mem_ack) begin
          wdata_q <= mem_rdata;
          if (k_q == K_POP) begin
            addr_q <= tgt_q;
            st     <= S_WR;
          end else begin
            tgt_q <= mem_rdata[HW-1:0];
            st    <= S_FIN;
          end
        end
        S_WR: if (mem_ack) st <= S_FIN;
        S_FIN:  st <= trap_q ? S_TRAP : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign mem_req     = (st == S_PUSH) || (st == S_RD) || (st == S_WR);
  assign mem_we      = (st == S_PUSH) || (st == S_WR);
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
  assign sp_we       = (st == S_FIN);
  assign sp_out      = ptr_q;
  assign jump_valid  = sp_we && ((k_q == K_PUSHJ) || (k_q == K_POPJ));
  assign jump_target = tgt_q;
  assign trap        = (st == S_TRAP);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_req || sp_we || jump_valid || trap));

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r11_no_req_at_wb: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> !mem_req);

  a_r13_trap_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(sp_we));

  a_r13_trap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !trap);

  a_r12_wb_ends_op: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |=> !sp_we);
endmodule

// File: tb/test_stack_ptr_engine.sv
`timescale 1ns/1ps
module test_stack_ptr_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  opcode = '0;
  logic [35:0] sp_in = '0, operand = '0;
  logic [17:0] ea = '0;
  logic        busy, mem_req, mem_we, sp_we, jump_valid, trap;
  logic [17:0] mem_addr, jump_target;
  logic [35:0] mem_wdata, sp_out;
  logic        mem_ack = 1'b0;
  logic [35:0] mem_rdata = '0;

  int tests = 0, fails = 0;
  logic [35:0] mem_m [logic [17:0]];

  always #2.5 clk = ~clk;

  stack_ptr_engine i_stack_ptr_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .sp_in(sp_in),
    .operand(operand), .ea(ea), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .sp_we(sp_we), .sp_out(sp_out),
    .jump_valid(jump_valid), .jump_target(jump_target), .trap(trap));

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %o expected %o at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit rq, input bit we, input logic [17:0] a, input logic [35:0] wd,
                     input bit aw, input logic [35:0] p, input bit jv, input logic [17:0] tg,
                     input bit tp, input bit bz, input string tag);
    logic [5:0] act, exp;
    act = {mem_req, mem_we & mem_req, sp_we, jump_valid, trap, busy};
    exp = {rq, we, aw, jv, tp, bz};
    chk(act === exp, tag, 36'(act), 36'(exp));
    if (rq) chk(mem_addr === a, tag, 36'(mem_addr), 36'(a));
    if (rq && we) chk(mem_wdata === wd, tag, mem_wdata, wd);
    if (aw) chk(sp_out === p, tag, sp_out, p);
    if (jv) chk(jump_target === tg, tag, 36'(jump_target), 36'(tg));
  endtask

  task automatic mem_phase(input bit we, input logic [17:0] a, input logic [35:0] wd,
                           input logic [35:0] rd, input int dly, input string tag);
    for (int d = 0; d <= dly; d++) begin
      cyc(1'b1, we, a, wd, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, tag);
      mem_ack = (d == dly);
      mem_rdata = rd;
      @(negedge clk);
    end
    mem_ack = 1'b0;
    mem_rdata = '0;
  endtask

  task automatic run_op(input logic [8:0] op, input logic [35:0] ptr, input logic [35:0] opnd,
                        input logic [17:0] e, input int dly, input bit spam, input string tag);
    logic [17:0] l, r, nl, nr, tg;
    logic [35:0] rd, wd;
    bit tr, jv;
    int kind;
    l = ptr[35:18]; r = ptr[17:0]; rd = '0; wd = '0;
    case (op)
      9'o261: kind = 0;
      9'o260: kind = 1;
      9'o262: kind = 2;
      9'o263: kind = 3;
      default: kind = 4;
    endcase
    if (kind <= 1) begin
      nl = l + 18'd1; nr = r + 18'd1; tr = (l == 18'o777777);
      wd = (kind == 1) ? opnd + 36'd1 : opnd;
    end else if (kind <= 3) begin
      nl = l - 18'd1; nr = r - 18'd1; tr = (l == 18'd0);
      rd = mem_m.exists(r) ? mem_m[r] : 36'd0;
    end else begin
      nl = l + e; nr = r + e;
      tr = e[17] ? (l[17] && !nl[17]) : (!l[17] && nl[17]);
    end
    jv = (kind == 1) || (kind == 3);
    tg = (kind == 1) ? e : rd[17:0];

    @(negedge clk);
    start = 1'b1; opcode = op; sp_in = ptr; operand = opnd; ea = e;
    @(negedge clk);
    if (spam) begin
      opcode = 9'o105; sp_in = ~ptr; operand = ~opnd; ea = 18'o000007;
    end else start = 1'b0;

    if (kind <= 1) begin
      mem_phase(1'b1, nr, wd, '0, dly, tag);
      mem_m[nr] = wd;
    end else if (kind <= 3) begin
      mem_phase(1'b0, r, '0, rd, dly, tag);
      if (kind == 2) begin
        mem_phase(1'b1, e, rd, '0, dly, tag);
        mem_m[e] = rd;
      end
    end
    start = 1'b0;
    cyc(1'b0, 1'b0, '0, '0, 1'b1, {nl, nr}, jv, tg, 1'b0, 1'b1, tag);
    @(negedge clk);
    if (tr) begin
      cyc(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b1, "R13");
      @(negedge clk);
    end
    cyc(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R13");
  endtask

  task automatic ignored(input logic [8:0] op);
    @(negedge clk);
    start = 1'b1; opcode = op; sp_in = 36'o777777000100; ea = 18'o000005;
    @(negedge clk);
    start = 1'b0;
    cyc(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R10");
    @(negedge clk);
    cyc(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R10");
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R1");

    run_op(9'o261, 36'o777775001000, 36'o123456701234, 18'o0, 0, 1'b0, "R2");
    run_op(9'o261, 36'o777760002000, 36'o707070707070, 18'o0, 3, 1'b1, "R2/R11/R12");
    run_op(9'o260, 36'o777770000100, 36'o000000004567, 18'o030000, 1, 1'b0, "R3");
    run_op(9'o261, 36'o777777777777, 36'o555555555555, 18'o0, 0, 1'b0, "R4");
    run_op(9'o260, 36'o777777000200, 36'o777777777777, 18'o040000, 2, 1'b0, "R4/R3");
    run_op(9'o262, 36'o777774001001, 36'o0, 18'o002000, 0, 1'b0, "R5");
    run_op(9'o262, 36'o777760002001, 36'o0, 18'o003000, 2, 1'b1, "R5/R11/R12");
    run_op(9'o263, 36'o777771000101, 36'o0, 18'o0, 1, 1'b0, "R6");
    run_op(9'o262, 36'o000000000005, 36'o0, 18'o004000, 2, 1'b0, "R7");
    run_op(9'o263, 36'o000000000201, 36'o0, 18'o0, 0, 1'b0, "R7/R6");
    run_op(9'o105, 36'o777770000100, 36'o0, 18'o000003, 0, 1'b0, "R8");
    run_op(9'o105, 36'o777776777777, 36'o0, 18'o000005, 0, 1'b0, "R9");
    run_op(9'o105, 36'o377777000010, 36'o0, 18'o000001, 0, 1'b0, "R9");
    run_op(9'o105, 36'o000002000100, 36'o0, 18'o777775, 0, 1'b0, "R9");
    run_op(9'o105, 36'o400000000010, 36'o0, 18'o777777, 0, 1'b0, "R9");
    run_op(9'o105, 36'o777776000010, 36'o0, 18'o777775, 0, 1'b0, "R8/R9");
    ignored(9'o264);
    ignored(9'o104);
    run_op(9'o261, 36'o777700000010, 36'o000111000222, 18'o0, 0, 1'b0, "R10/R2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule